// File: doc/BRIEF.md
# Non-Secure Window Firewall

This block sits in front of a memory target and decides, for every access, whether it may proceed. A secure master may reach any address. A non-secure master may reach an address only if that address falls inside one of six programmable windows that are currently switched on. Everything outside the enabled windows is reserved for secure masters. Out of reset every window is off, so the whole address space starts secure-only.

Each window holds a first page and a last page, compared at 4 KB granularity: only address bits [31:12] take part in the check. A window's on/off state lives in a single shared switch register. Software can write that register whole, or flip individual switches on or off through separate set and clear registers, so no read-modify-write is needed. Only a secure master may change any of this configuration. The allow output is combinational in the access address and secure flag and looks at the registered configuration. Returning data for a denied access, and the memory itself, are handled elsewhere.

Top module: `nsec_window_firewall`

## Requirements
- R1: After reset all six windows are off, and every non-secure access is denied at every address.
- R2: A secure access (`acc_secure`=1) is allowed at every address, whatever the configuration.
- R3: A non-secure access is allowed exactly when its page (address bits [31:12]) lies inside at least one enabled window; address bits [11:0] play no part in the decision.
- R4: A window covers the pages from its first page to its last page, both inclusive. A window whose last page is below its first page covers nothing, and a window with equal first and last pages covers exactly one 4 KB page.
- R5: A write to offset 0 (switch register) loads window i's switch from data bit i, for i = 0 to 5; data bits 6 and up are ignored.
- R6: A write to offset 1 (switch-on register) turns on each window whose data bit is 1 and leaves the other switches unchanged.
- R7: A write to offset 2 (switch-off register) turns off each window whose data bit is 1 and leaves the other switches unchanged.
- R8: A write to offset 4+2i loads window i's first page and a write to offset 5+2i loads its last page, each from data bits [31:12]; data bits [11:0] are dropped.
- R9: A configuration write with `cfg_wr_secure`=0 changes no switch, first page or last page.
- R10: A configuration write takes effect at the clock edge that accepts it; before that edge the decision uses the old configuration, and after it a change of address or secure flag alters `acc_allow` with no clock edge.
- R11: When windows overlap, a non-secure access is allowed if any enabled window covers it; turning off one of them leaves the part still covered by the other open.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 32 | Byte address of the access being checked |
| acc_secure | input | 1 | 1 when the access comes from a secure master |
| acc_allow | output | 1 | 1 when the access may proceed |
| cfg_wr_en | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wr_secure | input | 1 | 1 when the configuration write comes from a secure master |
| cfg_wr_addr | input | 4 | Configuration register offset |
| cfg_wr_data | input | 32 | Configuration write data |

## Verification
The bench goes after the window edges: the last byte before the first page, the first and last byte of each window and the first byte past it. An off-by-one compare would open a page too many or close the last page. It programs an inverted window and a one-page window, which would leak or shut out entirely under a strict or unsigned-wrap compare. It drives switch-on and switch-off writes with other windows already on, where a design that wrote the switch register whole would silently close or open neighbours. It also issues non-secure configuration writes, which a missing gate would turn into an open hole. A final test probes just before and just after the accepting edge, catching a design that registers the decision or bypasses the configuration register.

// File: rtl/nswf_pkg.sv
package nswf_pkg;

   // Register offsets of the configuration port; the window pairs are decoded
   // from these by the register file.
   localparam int unsigned OFF_SWITCH     = 0;
   localparam int unsigned OFF_SWITCH_ON  = 1;
   localparam int unsigned OFF_SWITCH_OFF = 2;
   localparam int unsigned OFF_WIN_FIRST  = 4;

   // Offset of the first-page register of a window.
   function automatic int unsigned first_offset(int unsigned idx);
      return OFF_WIN_FIRST + 2 * idx;
   endfunction

   // Offset of the last-page register of a window.
   function automatic int unsigned last_offset(int unsigned idx);
      return OFF_WIN_FIRST + 2 * idx + 1;
   endfunction

   // Number of offsets the register file occupies.
   function automatic int unsigned reg_span(int unsigned n_win);
      return OFF_WIN_FIRST + 2 * n_win;
   endfunction

endpackage

// File: rtl/nswf_win_match.sv
// One window comparator: hit when enabled and first <= page <= last.
module nswf_win_match #(
   parameter int unsigned PAGE_W = 20
) (
   input  logic [PAGE_W-1:0] page,
   input  logic [PAGE_W-1:0] first_pg,
   input  logic [PAGE_W-1:0] last_pg,
   input  logic              enabled,
   output logic              hit
);

   logic above_first;
   logic below_last;

   always_comb begin
      above_first = (page >= first_pg);
      below_last  = (page <= last_pg);
      hit         = enabled & above_first & below_last;
   end

endmodule

// File: rtl/nswf_cfg_regs.sv
// Secure-only configuration registers: switch bank and per-window page bounds.
module nswf_cfg_regs #(
   parameter int unsigned NUM_WIN   = 6,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   parameter int unsigned CFG_AW    = 4,
   localparam int unsigned PAGE_W   = ADDR_W - PAGE_BITS
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_secure,
   input  logic [CFG_AW-1:0]              wr_addr,
   input  logic [ADDR_W-1:0]              wr_data,
   output logic [NUM_WIN-1:0]             en_q,
   output logic [NUM_WIN-1:0][PAGE_W-1:0] first_q,
   output logic [NUM_WIN-1:0][PAGE_W-1:0] last_q
);

   localparam logic [CFG_AW-1:0] A_SWITCH = CFG_AW'(nswf_pkg::OFF_SWITCH);
   localparam logic [CFG_AW-1:0] A_ON     = CFG_AW'(nswf_pkg::OFF_SWITCH_ON);
   localparam logic [CFG_AW-1:0] A_OFF    = CFG_AW'(nswf_pkg::OFF_SWITCH_OFF);

   logic                wr_ok;
   logic [NUM_WIN-1:0]  wr_bits;
   logic [PAGE_W-1:0]   wr_page;
   logic [NUM_WIN-1:0]  en_d;
   logic                unused_low_data;

   assign wr_ok           = wr_en & wr_secure;
   assign wr_bits         = wr_data[NUM_WIN-1:0];
   assign wr_page         = wr_data[ADDR_W-1:PAGE_BITS];
   assign unused_low_data = ^wr_data;

   // Switch bank: whole write, set-by-one, clear-by-one.
   always_comb begin
      en_d = en_q;
      if (wr_ok) begin
         case (wr_addr)
            A_SWITCH: en_d = wr_bits;
            A_ON:     en_d = en_q | wr_bits;
            A_OFF:    en_d = en_q & ~wr_bits;
            default:  en_d = en_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
   end

   // Page bound registers, one pair per window.
   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      localparam logic [CFG_AW-1:0] A_FIRST = CFG_AW'(nswf_pkg::first_offset(g));
      localparam logic [CFG_AW-1:0] A_LAST  = CFG_AW'(nswf_pkg::last_offset(g));

      logic [PAGE_W-1:0] first_r;
      logic [PAGE_W-1:0] last_r;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            first_r <= '0;
            last_r  <= '0;
         end else if (wr_ok) begin
            if (wr_addr == A_FIRST) first_r <= wr_page;
            if (wr_addr == A_LAST)  last_r  <= wr_page;
         end
      end

      assign first_q[g] = first_r;
      assign last_q[g]  = last_r;
   end

endmodule

// File: rtl/nswf_decide.sv
// Final verdict: secure masters always pass, others need a window hit.
module nswf_decide #(
   parameter int unsigned NUM_WIN = 6
) (
   input  logic [NUM_WIN-1:0] hits,
   input  logic               acc_secure,
   output logic               allow
);

   logic any_hit;

   always_comb begin
      any_hit = |hits;
      allow   = acc_secure | any_hit;
   end

endmodule

// File: rtl/nsec_window_firewall.sv
module nsec_window_firewall #(
   parameter int unsigned NUM_WIN   = 6,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned PAGE_BITS = 12,
   localparam int unsigned CFG_AW   = $clog2(nswf_pkg::reg_span(NUM_WIN)),
   localparam int unsigned PAGE_W   = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_secure,
   output logic              acc_allow,
   input  logic              cfg_wr_en,
   input  logic              cfg_wr_secure,
   input  logic [CFG_AW-1:0] cfg_wr_addr,
   input  logic [ADDR_W-1:0] cfg_wr_data
);

   // Elaboration-time parameter checks.
   if (NUM_WIN < 1) begin : g_bad_count
      $error("nsec_window_firewall: NUM_WIN must be at least 1");
   end
   if (PAGE_BITS >= ADDR_W) begin : g_bad_page
      $error("nsec_window_firewall: PAGE_BITS must be below ADDR_W");
   end
   if (NUM_WIN > PAGE_BITS) begin : g_bad_overlap
      $error("nsec_window_firewall: switch bits must stay below the page field");
   end

   logic [NUM_WIN-1:0]             win_en;
   logic [NUM_WIN-1:0][PAGE_W-1:0] win_first;
   logic [NUM_WIN-1:0][PAGE_W-1:0] win_last;
   logic [NUM_WIN-1:0]             win_hit;
   logic [PAGE_W-1:0]              acc_page;
   logic                           unused_offset;

   assign acc_page      = acc_addr[ADDR_W-1:PAGE_BITS];
   assign unused_offset = ^acc_addr[PAGE_BITS-1:0];

   nswf_cfg_regs #(
      .NUM_WIN  (NUM_WIN),
      .ADDR_W   (ADDR_W),
      .PAGE_BITS(PAGE_BITS),
      .CFG_AW   (CFG_AW)
   ) i_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_wr_en),
      .wr_secure(cfg_wr_secure),
      .wr_addr  (cfg_wr_addr),
      .wr_data  (cfg_wr_data),
      .en_q     (win_en),
      .first_q  (win_first),
      .last_q   (win_last)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
      nswf_win_match #(
         .PAGE_W(PAGE_W)
      ) i_match (
         .page    (acc_page),
         .first_pg(win_first[w]),
         .last_pg (win_last[w]),
         .enabled (win_en[w]),
         .hit     (win_hit[w])
      );
   end

   nswf_decide #(
      .NUM_WIN(NUM_WIN)
   ) i_decide (
      .hits      (win_hit),
      .acc_secure(acc_secure),
      .allow     (acc_allow)
   );

endmodule

// File: rtl/nsec_window_firewall_chk.sv
module nsec_window_firewall_chk #(
   parameter int unsigned NUM_WIN = 6,
   parameter int unsigned CFG_AW  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_secure,
   input logic               acc_allow,
   input logic               cfg_wr_en,
   input logic               cfg_wr_secure,
   input logic [CFG_AW-1:0]  cfg_wr_addr,
   input logic [NUM_WIN-1:0] cfg_wr_bits,
   input logic [NUM_WIN-1:0] win_en
);

   localparam logic [CFG_AW-1:0] A_SWITCH = CFG_AW'(nswf_pkg::OFF_SWITCH);
   localparam logic [CFG_AW-1:0] A_ON     = CFG_AW'(nswf_pkg::OFF_SWITCH_ON);
   localparam logic [CFG_AW-1:0] A_OFF    = CFG_AW'(nswf_pkg::OFF_SWITCH_OFF);

   // R1: leaving reset, every switch is off.
   assert_reset_closed_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (win_en == '0));

   // R2: secure traffic is never blocked.
   assert_secure_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_secure |-> acc_allow);

   // R3: with no window on, non-secure traffic is blocked.
   assert_closed_default_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_secure && (win_en == '0)) |-> !acc_allow);

   // R5: a whole write of the switch register loads the data bits.
   assert_switch_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_secure && (cfg_wr_addr == A_SWITCH))
      |=> (win_en == $past(cfg_wr_bits)));

   // R6: switch-on sets the marked bits and keeps the others.
   assert_switch_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_secure && (cfg_wr_addr == A_ON))
      |=> (win_en == ($past(win_en) | $past(cfg_wr_bits))));

   // R7: switch-off clears the marked bits and keeps the others.
   assert_switch_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && cfg_wr_secure && (cfg_wr_addr == A_OFF))
      |=> (win_en == ($past(win_en) & ~$past(cfg_wr_bits))));

   // R9: a non-secure configuration write leaves the switches alone.
   assert_nonsec_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_en && !cfg_wr_secure) |=> $stable(win_en));

endmodule

bind nsec_window_firewall nsec_window_firewall_chk #(
   .NUM_WIN(NUM_WIN),
   .CFG_AW (CFG_AW)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .acc_secure   (acc_secure),
   .acc_allow    (acc_allow),
   .cfg_wr_en    (cfg_wr_en),
   .cfg_wr_secure(cfg_wr_secure),
   .cfg_wr_addr  (cfg_wr_addr),
   .cfg_wr_bits  (cfg_wr_data[NUM_WIN-1:0]),
   .win_en       (win_en)
);

// File: tb/test_nsec_window_firewall.sv
module test_nsec_window_firewall;

   localparam int NW  = 6;
   localparam int AW  = 32;
   localparam int PB  = 12;
   localparam int CAW = 4;
   localparam int PW  = AW - PB;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] acc_addr;
   logic          acc_secure;
   logic          acc_allow;
   logic          cfg_wr_en;
   logic          cfg_wr_secure;
   logic [CAW-1:0] cfg_wr_addr;
   logic [AW-1:0] cfg_wr_data;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   // Bench model of the configuration, kept from the requirements.
   logic [NW-1:0] m_en;
   logic [PW-1:0] m_first [NW];
   logic [PW-1:0] m_last  [NW];

   always #4 clk = ~clk;

   nsec_window_firewall i_nsec_window_firewall (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_addr     (acc_addr),
      .acc_secure   (acc_secure),
      .acc_allow    (acc_allow),
      .cfg_wr_en    (cfg_wr_en),
      .cfg_wr_secure(cfg_wr_secure),
      .cfg_wr_addr  (cfg_wr_addr),
      .cfg_wr_data  (cfg_wr_data)
   );

   function automatic bit exp_allow(logic [AW-1:0] a, logic s);
      bit r = s;
      for (int i = 0; i < NW; i++)
         if (m_en[i] && (a[AW-1:PB] >= m_first[i]) && (a[AW-1:PB] <= m_last[i])) r = 1'b1;
      return r;
   endfunction

   // Apply the model update that a write accepted at an edge implies.
   task automatic model_write(logic [CAW-1:0] a, logic [AW-1:0] d, logic s);
      int idx;
      if (!s) return;
      if (a == 0)      m_en = d[NW-1:0];
      else if (a == 1) m_en = m_en | d[NW-1:0];
      else if (a == 2) m_en = m_en & ~d[NW-1:0];
      else if (a >= 4 && a < 4 + 2 * NW) begin
         idx = (int'(a) - 4) / 2;
         if (a[0] == 1'b0) m_first[idx] = d[AW-1:PB];
         else              m_last[idx]  = d[AW-1:PB];
      end
   endtask

   task automatic probe(string req, logic [AW-1:0] a, logic s);
      bit exp;
      acc_addr   = a;
      acc_secure = s;
      #1;
      exp = exp_allow(a, s);
      n_vec++;
      if (acc_allow !== exp) begin
         n_bad++;
         $display("FAIL %s addr=%h secure=%0b allow=%0b expected=%0b", req, a, s, acc_allow, exp);
      end
   endtask

   task automatic wr(logic [CAW-1:0] a, logic [AW-1:0] d, logic s);
      @(negedge clk);
      cfg_wr_en     = 1'b1;
      cfg_wr_secure = s;
      cfg_wr_addr   = a;
      cfg_wr_data   = d;
      @(posedge clk);
      model_write(a, d, s);
      @(negedge clk);
      cfg_wr_en     = 1'b0;
      cfg_wr_secure = 1'b0;
   endtask

   task automatic t_reset;
      probe("R1", 32'h0000_0000, 1'b0);
      probe("R1", 32'hFFFF_FFFF, 1'b0);
      probe("R1", 32'h1000_0000, 1'b0);
      probe("R2", 32'h0000_0000, 1'b1);
   endtask

   task automatic t_window_bounds;
      wr(4'd4, 32'h1000_0ABC, 1'b1);
      wr(4'd5, 32'h1000_3123, 1'b1);
      probe("R3 window off ignores bounds", 32'h1000_0000, 1'b0);
      wr(4'd0, 32'h0000_0001, 1'b1);
      probe("R3 below first", 32'h0FFF_FFFF, 1'b0);
      probe("R8 first byte", 32'h1000_0000, 1'b0);
      probe("R8 last byte", 32'h1000_3FFF, 1'b0);
      probe("R4 past last", 32'h1000_4000, 1'b0);
      probe("R3 offset bits", 32'h1000_2FFF, 1'b0);
   endtask

   task automatic t_switch_reg;
      wr(4'd0, 32'hFFFF_FFC0, 1'b1);
      probe("R5 upper bits ignored", 32'h1000_0000, 1'b0);
      wr(4'd0, 32'h0000_0001, 1'b1);
      probe("R5 reload", 32'h1000_0000, 1'b0);
   endtask

   task automatic t_inverted;
      wr(4'd6, 32'h2000_0000, 1'b1);
      wr(4'd7, 32'h1FFF_0000, 1'b1);
      wr(4'd1, 32'h0000_0002, 1'b1);
      probe("R4 inverted first", 32'h2000_0000, 1'b0);
      probe("R4 inverted last", 32'h1FFF_0000, 1'b0);
      probe("R4 inverted middle", 32'h1FFF_8000, 1'b0);
      wr(4'd8, 32'h3000_5000, 1'b1);
      wr(4'd9, 32'h3000_5000, 1'b1);
      wr(4'd1, 32'h0000_0004, 1'b1);
      probe("R4 one page low", 32'h3000_5000, 1'b0);
      probe("R4 one page high", 32'h3000_5FFF, 1'b0);
      probe("R4 one page before", 32'h3000_4FFF, 1'b0);
      probe("R4 one page after", 32'h3000_6000, 1'b0);
      probe("R6 neighbour kept", 32'h1000_1000, 1'b0);
   endtask

   task automatic t_set_clear;
      wr(4'd14, 32'hF000_0000, 1'b1);
      wr(4'd15, 32'hFFFF_FFFF, 1'b1);
      wr(4'd1, 32'h0000_0020, 1'b1);
      probe("R6 top window", 32'hFFFF_FFFF, 1'b0);
      probe("R6 others kept", 32'h1000_0000, 1'b0);
      wr(4'd2, 32'h0000_0001, 1'b1);
      probe("R7 cleared", 32'h1000_0000, 1'b0);
      probe("R7 others kept", 32'hF000_0000, 1'b0);
      wr(4'd2, 32'h0000_0000, 1'b1);
      probe("R7 zero no effect", 32'h3000_5000, 1'b0);
   endtask

   task automatic t_nonsec_write;
      wr(4'd0, 32'h0000_003F, 1'b0);
      wr(4'd15, 32'h0000_0000, 1'b0);
      wr(4'd4, 32'h0000_0000, 1'b0);
      probe("R9 switch untouched", 32'h1000_0000, 1'b0);
      probe("R9 bound untouched", 32'hF800_0000, 1'b0);
      wr(4'd2, 32'h0000_003F, 1'b0);
      probe("R9 clear ignored", 32'hF800_0000, 1'b0);
   endtask

   task automatic t_overlap;
      wr(4'd10, 32'h4000_0000, 1'b1);
      wr(4'd11, 32'h4FFF_FFFF, 1'b1);
      wr(4'd12, 32'h4800_0000, 1'b1);
      wr(4'd13, 32'h5FFF_FFFF, 1'b1);
      wr(4'd1, 32'h0000_0018, 1'b1);
      probe("R11 shared", 32'h4800_0000, 1'b0);
      probe("R11 second only", 32'h5FFF_F000, 1'b0);
      probe("R11 beyond", 32'h6000_0000, 1'b0);
      wr(4'd2, 32'h0000_0008, 1'b1);
      probe("R11 first off", 32'h4000_0000, 1'b0);
      probe("R11 still covered", 32'h4800_0000, 1'b0);
   endtask

   task automatic t_secure;
      probe("R2 outside", 32'h6000_0000, 1'b1);
      probe("R2 inside", 32'h4800_0000, 1'b1);
      probe("R2 inverted", 32'h2000_0000, 1'b1);
   endtask

   task automatic t_timing;
      wr(4'd2, 32'h0000_003F, 1'b1);
      wr(4'd4, 32'h1000_0000, 1'b1);
      @(negedge clk);
      cfg_wr_en     = 1'b1;
      cfg_wr_secure = 1'b1;
      cfg_wr_addr   = 4'd1;
      cfg_wr_data   = 32'h0000_0001;
      probe("R10 before edge", 32'h1000_0000, 1'b0);
      @(posedge clk);
      model_write(4'd1, 32'h0000_0001, 1'b1);
      probe("R10 after edge", 32'h1000_0000, 1'b0);
      @(negedge clk);
      cfg_wr_en     = 1'b0;
      cfg_wr_secure = 1'b0;
      probe("R10 address change", 32'h1000_4000, 1'b0);
      probe("R10 address back", 32'h1000_3000, 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog R1..all: state=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n         = 1'b0;
      acc_addr      = '0;
      acc_secure    = 1'b0;
      cfg_wr_en     = 1'b0;
      cfg_wr_secure = 1'b0;
      cfg_wr_addr   = '0;
      cfg_wr_data   = '0;
      m_en          = '0;
      for (int i = 0; i < NW; i++) begin
         m_first[i] = '0;
         m_last[i]  = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_window_bounds();
      t_switch_reg();
      t_inverted();
      t_set_clear();
      t_nonsec_write();
      t_overlap();
      t_secure();
      t_timing();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule